// File: doc/BRIEF.md
# Multi-Mode Logarithmic Barrel Shifter

This block is a purely combinational shifter for a word of `WIDTH` bits (8 by default). It takes a data word, a shift distance from 0 to `WIDTH-1` and a 3-bit operation code. It returns a word of the same width that holds the data shifted or rotated in the chosen direction. The block has no clock and no storage, so the result follows the inputs within the same cycle.

The datapath is a chain of `log2(WIDTH)` levels of 2-to-1 multiplexers. When bit k of the distance is set, level k moves the word right by 2^k positions. Each level fills the positions it vacates from one of three sources: constant zero, the sign bit of the original word, or the bits that fall off the low end. Left operations reuse the same chain. The word is mirrored before the chain and mirrored back after it. A small decoder turns the operation code into three controls: the mirror enable, the fill source, and a distance that is forced to zero for unused codes.

The operation control has no states or transitions. The decoder is a single combinational selection over the five valid codes plus a default, and every code is listed in the requirements.

Top module: `bshift_core`

## Requirements
- R1: Code 3'b000 (logical left) moves every bit up by the distance and writes 0 into the vacated low positions.
- R2: Code 3'b001 (logical right) moves every bit down by the distance and writes 0 into the vacated high positions.
- R3: Code 3'b010 (arithmetic right) moves every bit down by the distance and writes copies of the input's most significant bit into the vacated high positions.
- R4: Code 3'b011 (rotate left) moves every bit up by the distance, and the bits shifted out at the top re-enter at the bottom.
- R5: Code 3'b100 (rotate right) moves every bit down by the distance, and the bits shifted out at the bottom re-enter at the top.
- R6: Codes 3'b101, 3'b110 and 3'b111 return the data input unchanged for every distance.
- R7: A distance of 0 returns the data input unchanged under every code.
- R8: Rotations never change the number of set bits in the word.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| data_i | input | WIDTH | Word to shift or rotate |
| amount_i | input | $clog2(WIDTH) | Shift distance, 0 to WIDTH-1 |
| mode_i | input | 3 | Operation code (see R1 to R6) |
| result_o | output | WIDTH | Shifted or rotated word |

## Verification
A directed table applies words with distinct end bits to each operation. Examples are 8'hD3 with a distance of 1, 8'h80 against 8'h7F for an arithmetic shift of 7, and 8'h81 for rotations. These separate zero fill from sign fill from wrap-around, and separate a left move from a right move. All 256 data values are then run against every distance under all eight codes and compared with an operator-based reference model. This run catches a level that ignores its distance bit, a wrong fill source at any level, and a mirror that is not applied.

// File: rtl/bshift_pkg.sv
package bshift_pkg;

    typedef enum logic [2:0] {
        OP_SLL = 3'b000,
        OP_SRL = 3'b001,
        OP_SRA = 3'b010,
        OP_ROL = 3'b011,
        OP_ROR = 3'b100
    } shift_op_e;

    typedef enum logic [1:0] {
        FILL_ZERO = 2'd0,
        FILL_SIGN = 2'd1,
        FILL_WRAP = 2'd2
    } fill_src_e;

endpackage

// File: rtl/bshift_ctrl.sv
module bshift_ctrl
    import bshift_pkg::*;
#(
    parameter int AMT_W = 3
) (
    input  logic [2:0]       mode_i,
    input  logic [AMT_W-1:0] amount_i,
    output logic             mirror_o,
    output fill_src_e        fill_o,
    output logic [AMT_W-1:0] amount_o
);

    always_comb begin
        mirror_o = 1'b0;
        fill_o   = FILL_ZERO;
        amount_o = amount_i;
        unique case (mode_i)
            OP_SLL: mirror_o = 1'b1;
            OP_SRL: fill_o   = FILL_ZERO;
            OP_SRA: fill_o   = FILL_SIGN;
            OP_ROL: begin
                mirror_o = 1'b1;
                fill_o   = FILL_WRAP;
            end
            OP_ROR: fill_o   = FILL_WRAP;
            default: amount_o = '0;
        endcase
    end

    // R6: unused codes must not move the word
    always_comb begin
        if (mode_i > 3'b100) begin
            p_unused_code_still_r6: assert (amount_o == '0)
                else $error("unused code produced a nonzero distance");
        end
    end

endmodule

// File: rtl/bshift_mirror.sv
module bshift_mirror #(
    parameter int WIDTH = 8
) (
    input  logic [WIDTH-1:0] word_i,
    output logic [WIDTH-1:0] word_o
);

    for (genvar i = 0; i < WIDTH; i++) begin : g_bit
        assign word_o[i] = word_i[WIDTH-1-i];
    end

endmodule

// File: rtl/bshift_stage.sv
module bshift_stage
    import bshift_pkg::*;
#(
    parameter int WIDTH = 8,
    parameter int DIST  = 1
) (
    input  logic [WIDTH-1:0] word_i,
    input  logic             en_i,
    input  fill_src_e        fill_i,
    input  logic             sign_i,
    output logic [WIDTH-1:0] word_o
);

    for (genvar i = 0; i < WIDTH; i++) begin : g_bit
        if (i + DIST < WIDTH) begin : g_inner
            assign word_o[i] = en_i ? word_i[i+DIST] : word_i[i];
        end else begin : g_edge
            logic fill_bit;
            assign fill_bit = (fill_i == FILL_WRAP) ? word_i[i+DIST-WIDTH] :
                              (fill_i == FILL_SIGN) ? sign_i : 1'b0;
            assign word_o[i] = en_i ? fill_bit : word_i[i];
        end
    end

    // R7: a level whose distance bit is clear passes its word through
    always_comb begin
        if (!en_i) begin
            p_level_hold_r7: assert (word_o == word_i)
                else $error("idle level altered the word");
        end
    end

endmodule

// File: rtl/bshift_core.sv
module bshift_core
    import bshift_pkg::*;
#(
    parameter int WIDTH = 8
) (
    input  logic [WIDTH-1:0]         data_i,
    input  logic [$clog2(WIDTH)-1:0] amount_i,
    input  logic [2:0]               mode_i,
    output logic [WIDTH-1:0]         result_o
);

    localparam int AMT_W  = $clog2(WIDTH);
    localparam int LEVELS = AMT_W;

    logic             mirror;
    fill_src_e        fill_src;
    logic [AMT_W-1:0] amt_eff;
    logic [WIDTH-1:0] data_flip;
    logic [WIDTH-1:0] chain_in;
    logic [WIDTH-1:0] res_flip;
    logic [WIDTH-1:0] chain [LEVELS+1];

    bshift_ctrl #(.AMT_W(AMT_W)) u_ctrl (
        .mode_i   (mode_i),
        .amount_i (amount_i),
        .mirror_o (mirror),
        .fill_o   (fill_src),
        .amount_o (amt_eff)
    );

    bshift_mirror #(.WIDTH(WIDTH)) u_mirror_in (
        .word_i (data_i),
        .word_o (data_flip)
    );

    assign chain_in = mirror ? data_flip : data_i;
    assign chain[0] = chain_in;

    for (genvar k = 0; k < LEVELS; k++) begin : g_level
        bshift_stage #(.WIDTH(WIDTH), .DIST(1 << k)) u_stage (
            .word_i (chain[k]),
            .en_i   (amt_eff[k]),
            .fill_i (fill_src),
            .sign_i (data_i[WIDTH-1]),
            .word_o (chain[k+1])
        );
    end

    bshift_mirror #(.WIDTH(WIDTH)) u_mirror_out (
        .word_i (chain[LEVELS]),
        .word_o (res_flip)
    );

    assign result_o = mirror ? res_flip : chain[LEVELS];

    always_comb begin
        if (amount_i == '0) begin
            p_zero_dist_r7: assert (result_o == data_i)
                else $error("zero distance changed the word");
        end
        if (mode_i > 3'b100) begin
            p_unused_pass_r6: assert (result_o == data_i)
                else $error("unused code changed the word");
        end
        if (mode_i == 3'b011 || mode_i == 3'b100) begin
            p_rot_popcount_r8: assert ($countones(result_o) == $countones(data_i))
                else $error("rotation changed the set-bit count");
        end
        for (int j = 0; j < WIDTH; j++) begin
            if (mode_i == 3'b000 && j < int'(amount_i)) begin
                p_sll_zero_fill_r1: assert (result_o[j] == 1'b0)
                    else $error("left shift left a low bit set");
            end
            if (mode_i == 3'b001 && j >= WIDTH - int'(amount_i)) begin
                p_srl_zero_fill_r2: assert (result_o[j] == 1'b0)
                    else $error("logical right left a high bit set");
            end
            if (mode_i == 3'b010 && j >= WIDTH - int'(amount_i)) begin
                p_sra_sign_fill_r3: assert (result_o[j] == data_i[WIDTH-1])
                    else $error("arithmetic right filled a non-sign bit");
            end
        end
    end

endmodule

// File: tb/bshift_core_bench.sv
module bshift_core_bench;

    localparam int W    = 8;
    localparam int AW   = 3;
    localparam int NVEC = 14;

    logic          clk = 1'b0;
    logic [W-1:0]  data;
    logic [AW-1:0] amt;
    logic [2:0]    mode;
    logic [W-1:0]  result;

    int n_vec  = 0;
    int n_fail = 0;
    int cycles = 0;
    bit done   = 1'b0;

    always #2.5 clk = ~clk;

    bshift_core #(.WIDTH(W)) u_bshift_core (
        .data_i   (data),
        .amount_i (amt),
        .mode_i   (mode),
        .result_o (result)
    );

    // {data, distance, code, expected}
    localparam logic [21:0] TABLE [NVEC] = '{
        {8'hD3, 3'd1, 3'b000, 8'hA6},  // R1
        {8'hD3, 3'd1, 3'b001, 8'h69},  // R2
        {8'hD3, 3'd1, 3'b010, 8'hE9},  // R3
        {8'hD3, 3'd1, 3'b011, 8'hA7},  // R4
        {8'hD3, 3'd1, 3'b100, 8'hE9},  // R5
        {8'h80, 3'd7, 3'b010, 8'hFF},  // R3
        {8'h7F, 3'd7, 3'b010, 8'h00},  // R3
        {8'h81, 3'd4, 3'b011, 8'h18},  // R4
        {8'h81, 3'd3, 3'b100, 8'h30},  // R5
        {8'hFF, 3'd7, 3'b000, 8'h80},  // R1
        {8'hFF, 3'd7, 3'b001, 8'h01},  // R2
        {8'h5A, 3'd5, 3'b101, 8'h5A},  // R6
        {8'h5A, 3'd3, 3'b111, 8'h5A},  // R6
        {8'hC3, 3'd0, 3'b010, 8'hC3}   // R7
    };

    localparam string TAGS [NVEC] = '{
        "R1", "R2", "R3", "R4", "R5", "R3", "R3",
        "R4", "R5", "R1", "R2", "R6", "R6", "R7"
    };

    function automatic logic [W-1:0] model(input logic [W-1:0] d,
                                           input int a, input logic [2:0] m);
        logic [W-1:0] r;
        case (m)
            3'b000:  r = d << a;
            3'b001:  r = d >> a;
            3'b010:  r = $signed(d) >>> a;
            3'b011:  r = (d << a) | (d >> (W - a));
            3'b100:  r = (d >> a) | (d << (W - a));
            default: r = d;
        endcase
        return r;
    endfunction

    function automatic string tag_of(input logic [2:0] m, input int a);
        if (a == 0) return "R7";
        case (m)
            3'b000:  return "R1";
            3'b001:  return "R2";
            3'b010:  return "R3";
            3'b011:  return "R4";
            3'b100:  return "R5";
            default: return "R6";
        endcase
    endfunction

    task automatic apply(input logic [W-1:0] d, input int a,
                         input logic [2:0] m, input logic [W-1:0] exp,
                         input string req);
        @(negedge clk);
        data = d;
        amt  = AW'(a);
        mode = m;
        @(posedge clk);
        #1;
        n_vec++;
        if (result !== exp) begin
            n_fail++;
            $display("FAIL %s: data=%h dist=%0d code=%b got %h expected %h",
                     req, d, a, m, result, exp);
        end
    endtask

    always @(posedge clk) begin
        cycles <= cycles + 1;
        if (cycles >= 150000 && !done) begin
            n_fail++;
            $display("FAIL watchdog: got hung run, expected completion");
            $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_fail);
            $finish;
        end
    end

    initial begin
        data = '0;
        amt  = '0;
        mode = '0;
        // initial state: zero distance, code 000, passes word through (R7)
        apply(8'h00, 0, 3'b000, 8'h00, "R7");

        for (int v = 0; v < NVEC; v++) begin
            apply(TABLE[v][21:14], int'(TABLE[v][13:11]), TABLE[v][10:8],
                  TABLE[v][7:0], TAGS[v]);
        end

        // R8: set-bit count preserved by rotations, checked via the model result
        for (int a = 0; a < W; a++) begin
            apply(8'hB1, a, 3'b011, model(8'hB1, a, 3'b011), "R8");
            apply(8'hB1, a, 3'b100, model(8'hB1, a, 3'b100), "R8");
        end

        // exhaustive sweep against the operator model
        for (int m = 0; m < 8; m++) begin
            for (int a = 0; a < W; a++) begin
                for (int d = 0; d < 256; d++) begin
                    apply(W'(d), a, 3'(m), model(W'(d), a, 3'(m)),
                          tag_of(3'(m), a));
                end
            end
        end

        done = 1'b1;
        $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_fail);
        $finish;
    end

endmodule